// File: doc/BRIEF.md
# Fixed Off-Time Current Chopping Timer

This block sequences the internal current regulation of an H-bridge motor driver. It runs on the oscillator clock. It drives the bridge on and watches a sense-comparator trip input. It then holds the bridge in current decay for a programmed fixed time, and masks the comparator for a programmed blanking window before watching it again. Three outputs tell the gate-drive logic which phase is active: drive, fast decay or slow decay.

The decay period can be split into two parts. In mixed mode, a programmable fast-decay part comes first and slow decay fills the rest. In slow mode, the whole period is slow decay. A blanking window hides the switching spike after each turn-on. The blanking window restarts whenever the direction input toggles. When the block is not enabled, it rests in an idle state with every output low.

Top module: `chopTimer`

## Requirements
- R1: While reset is asserted and on the first cycles after it, with `runEn` low, `driveOn`, `fastDecay` and `slowDecay` are all low.
- R2: A cycle with `runEn` low makes all three outputs low from the next cycle. After `runEn` rises, one idle cycle passes, and then blanking begins.
- R3: Blanking lasts 4*(B+1) cycles, where B is `blankCode`, with `driveOn` high. The on phase follows directly, also with `driveOn` high.
- R4: A `senseTrip` that arrives during blanking is ignored: `driveOn` stays high until blanking ends.
- R5: `senseTrip` high in an on-phase cycle ends the on phase. From the next cycle `driveOn` is low and a decay output is high.
- R6: The decay period lasts 8*N+7 cycles, where N is `offCode`. After it, blanking starts again.
- R7: With `mixedSel` high, the first min(8*F+7, 8*N+7) decay cycles drive `fastDecay`, where F is `fastCode`. The remaining decay cycles drive `slowDecay`.
- R8: With `mixedSel` high and 8*F+7 ≥ 8*N+7, the whole decay period is fast decay.
- R9: With `mixedSel` low, the whole decay period is slow decay, whatever `fastCode` holds.
- R10: A change of `phaseIn` while the block is active restarts blanking from the next cycle. This takes precedence over a trip and over the decay count.
- R11: At most one output is high in any cycle. Exactly one is high whenever the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Outputs enabled and not asleep |
| phaseIn | input | 1 | Bridge direction; any change restarts blanking |
| senseTrip | input | 1 | Sense comparator trip, high when current exceeds its limit |
| mixedSel | input | 1 | 1 = mixed decay, 0 = slow decay |
| offCode | input | 5 | Decay period code N: 8N+7 cycles |
| fastCode | input | 4 | Fast-decay part code F: 8F+7 cycles |
| blankCode | input | 2 | Blanking code B: 4(B+1) cycles |
| driveOn | output | 1 | Bridge driving (blanking or on phase) |
| fastDecay | output | 1 | Fast-decay recirculation active |
| slowDecay | output | 1 | Slow-decay recirculation active |

## Verification
A wrong phase counter appears at the ports as a decay or blanking period with the wrong length. It also appears as a fast-to-slow switch at the wrong position. Either shows on the first period after the fault, because the bench compares all three outputs on every cycle against a behavioural model. A wrong state transition shows within one cycle. Examples are a trip accepted during blanking, or a phase toggle that does not restart blanking: `driveOn` would drop early or fail to stay high.

// File: rtl/chop_pkg.sv
package chop_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_OFF   = 2'd3
  } chopState_t;

  // strobes from the sequencer to the phase counter
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/chopDp.sv
module chopDp
  import chop_pkg::*;
#(
  parameter int OFF_W    = 5,
  parameter int FAST_W   = 4,
  parameter int BLK_W    = 2,
  parameter int STEP     = 8,
  parameter int BASE     = 7,
  parameter int BLK_STEP = 4,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        stb,
  input  logic              mixedSel,
  input  logic [OFF_W-1:0]  offCode,
  input  logic [FAST_W-1:0] fastCode,
  input  logic [BLK_W-1:0]  blankCode,
  output logic              blankDone,
  output logic              offDone,
  output logic              fastWin
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] offLen;
  logic [CNT_W-1:0] fastLen;
  logic [CNT_W-1:0] blankLen;

  assign offLen   = CNT_W'(offCode) * CNT_W'(STEP) + CNT_W'(BASE);
  assign fastLen  = CNT_W'(fastCode) * CNT_W'(STEP) + CNT_W'(BASE);
  assign blankLen = (CNT_W'(blankCode) + CNT_W'(1)) * CNT_W'(BLK_STEP);

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (stb.clr) cnt <= '0;
    else if (stb.inc) cnt <= cnt + CNT_W'(1);
  end

  assign blankDone = (cnt == blankLen - CNT_W'(1));
  assign offDone   = (cnt == offLen - CNT_W'(1));
  assign fastWin   = mixedSel && (cnt < fastLen);
endmodule

// File: rtl/chopCtl.sv
module chopCtl
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       phaseIn,
  input  logic       senseTrip,
  input  logic       blankDone,
  input  logic       offDone,
  output cntStrobe_t stb,
  output chopState_t state
);
  chopState_t nxt;
  logic phasePrev;
  logic phaseChg;

  // direction history needs no reset: it is only consulted outside idle
  always_ff @(posedge clk) phasePrev <= phaseIn;
  assign phaseChg = (phaseIn != phasePrev);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    if (!runEn) begin
      nxt     = ST_IDLE;
      stb.clr = 1'b1;
    end else if (state != ST_IDLE && phaseChg) begin
      nxt     = ST_BLANK;
      stb.clr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nxt     = ST_BLANK;
          stb.clr = 1'b1;
        end
        ST_BLANK: begin
          if (blankDone) begin
            nxt     = ST_ON;
            stb.clr = 1'b1;
          end else begin
            stb.inc = 1'b1;
          end
        end
        ST_ON: begin
          if (senseTrip) begin
            nxt     = ST_OFF;
            stb.clr = 1'b1;
          end
        end
        ST_OFF: begin
          if (offDone) begin
            nxt     = ST_BLANK;
            stb.clr = 1'b1;
          end else begin
            stb.inc = 1'b1;
          end
        end
        default: begin
          nxt     = ST_IDLE;
          stb.clr = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/chopTimer.sv
module chopTimer
  import chop_pkg::*;
#(
  parameter int OFF_W    = 5,
  parameter int FAST_W   = 4,
  parameter int BLK_W    = 2,
  parameter int STEP     = 8,
  parameter int BASE     = 7,
  parameter int BLK_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              phaseIn,
  input  logic              senseTrip,
  input  logic              mixedSel,
  input  logic [OFF_W-1:0]  offCode,
  input  logic [FAST_W-1:0] fastCode,
  input  logic [BLK_W-1:0]  blankCode,
  output logic              driveOn,
  output logic              fastDecay,
  output logic              slowDecay
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int OFF_MAX  = (2**OFF_W - 1) * STEP + BASE;
  localparam int FAST_MAX = (2**FAST_W - 1) * STEP + BASE;
  localparam int BLK_MAX  = (2**BLK_W) * BLK_STEP;
  localparam int LEN_A    = (OFF_MAX > FAST_MAX) ? OFF_MAX : FAST_MAX;
  localparam int LEN_MAX  = (LEN_A > BLK_MAX) ? LEN_A : BLK_MAX;
  localparam int CNT_W    = $clog2(LEN_MAX + 1);

  cntStrobe_t ctlStb;
  chopState_t ctlState;
  logic blankDone, offDone, fastWin;

  chopCtl uCtl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .phaseIn(phaseIn),
    .senseTrip(senseTrip), .blankDone(blankDone), .offDone(offDone),
    .stb(ctlStb), .state(ctlState)
  );

  chopDp #(
    .OFF_W(OFF_W), .FAST_W(FAST_W), .BLK_W(BLK_W), .STEP(STEP),
    .BASE(BASE), .BLK_STEP(BLK_STEP), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .mixedSel(mixedSel),
    .offCode(offCode), .fastCode(fastCode), .blankCode(blankCode),
    .blankDone(blankDone), .offDone(offDone), .fastWin(fastWin)
  );

  assign driveOn   = (ctlState == ST_BLANK) || (ctlState == ST_ON);
  assign fastDecay = (ctlState == ST_OFF) && fastWin;
  assign slowDecay = (ctlState == ST_OFF) && !fastWin;
endmodule

// File: rtl/chopTimerChecker.sv
module chopTimerChecker
  import chop_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       runEn,
  input logic       phaseIn,
  input logic       senseTrip,
  input logic       driveOn,
  input logic       fastDecay,
  input logic       slowDecay,
  input chopState_t state
);
  timeunit 1ns;
  timeprecision 100ps;

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({driveOn, fastDecay, slowDecay}));

  p_active_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> ($countones({driveOn, fastDecay, slowDecay}) == 1));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!driveOn && !fastDecay && !slowDecay));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $stable(phaseIn) && state == ST_BLANK && senseTrip) |=> driveOn);

  p_trip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $stable(phaseIn) && state == ST_ON && senseTrip)
      |=> (!driveOn && (fastDecay || slowDecay)));

  p_phase_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !$stable(phaseIn) && state != ST_IDLE) |=> (state == ST_BLANK));
endmodule

bind chopTimer chopTimerChecker uChk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .phaseIn(phaseIn),
  .senseTrip(senseTrip), .driveOn(driveOn), .fastDecay(fastDecay),
  .slowDecay(slowDecay), .state(ctlState)
);

// File: tb/tb_chopTimer.sv
module tb_chopTimer;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, phaseIn = 1'b0, senseTrip = 1'b0, mixedSel = 1'b0;
  logic [4:0] offCode = '0;
  logic [3:0] fastCode = '0;
  logic [1:0] blankCode = '0;
  logic driveOn, fastDecay, slowDecay;

  int checks = 0, failures = 0;
  bit done = 0;
  logic sDrive, sFast, sSlow;

  // behavioural reference: 0 idle, 1 blank, 2 on, 3 decay
  int mState = 0, mCnt = 0;
  logic mPrev = 1'b0;

  always #2.5 clk = ~clk;

  chopTimer dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .phaseIn(phaseIn),
    .senseTrip(senseTrip), .mixedSel(mixedSel), .offCode(offCode),
    .fastCode(fastCode), .blankCode(blankCode), .driveOn(driveOn),
    .fastDecay(fastDecay), .slowDecay(slowDecay)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int blkLen();
    return 4 * (int'(blankCode) + 1);
  endfunction

  function automatic int offLen();
    return 8 * int'(offCode) + 7;
  endfunction

  function automatic int fastLen();
    return 8 * int'(fastCode) + 7;
  endfunction

  // one clock: compare before the edge, advance the model at the edge
  task automatic cycle();
    logic eD, eF, eS;
    #1.5;
    sDrive = driveOn; sFast = fastDecay; sSlow = slowDecay;
    eD = (mState == 1) || (mState == 2);
    eF = (mState == 3) && mixedSel && (mCnt < fastLen());
    eS = (mState == 3) && !eF;
    check(mState == 3 ? "R7 model decay" : (mState == 0 ? "R2 model idle" : "R3 model drive"),
          {sDrive, sFast, sSlow}, {eD, eF, eS});
    @(posedge clk);
    if (!rstN) begin
      mState = 0; mCnt = 0;
    end else if (!runEn) begin
      mState = 0; mCnt = 0;
    end else if (mState != 0 && phaseIn != mPrev) begin
      mState = 1; mCnt = 0;
    end else begin
      case (mState)
        0: begin mState = 1; mCnt = 0; end
        1: if (mCnt + 1 == blkLen()) begin mState = 2; mCnt = 0; end else mCnt++;
        2: if (senseTrip) begin mState = 3; mCnt = 0; end
        default: if (mCnt + 1 == offLen()) begin mState = 1; mCnt = 0; end else mCnt++;
      endcase
    end
    mPrev = phaseIn;
    @(negedge clk);
  endtask

  // one full chopping period with the trip held high
  task automatic runPeriod(int expOn, int expFast, int expSlow);
    int n, f, s;
    runEn = 1'b1; senseTrip = 1'b1;
    cycle();
    check("R2 idle cycle after enable", sDrive, 0);
    cycle();
    n = 0;
    while (sDrive && n < 600) begin n++; cycle(); end
    check("R3 R4 R5 drive cycles", n, expOn);
    f = 0;
    while (sFast && f < 600) begin f++; cycle(); end
    check("R7 R8 fast decay cycles", f, expFast);
    s = 0;
    while (sSlow && s < 600) begin s++; cycle(); end
    check("R9 slow decay cycles", s, expSlow);
    check("R6 decay total", f + s, offLen());
    check("R6 blank after decay", sDrive, 1);
    runEn = 1'b0; senseTrip = 1'b0;
    cycle();
    cycle();
    check("R2 disabled outputs", {sDrive, sFast, sSlow}, 0);
  endtask

  initial begin
    @(negedge clk);
    cycle(); cycle(); cycle();
    check("R1 reset outputs", {sDrive, sFast, sSlow}, 0);
    rstN = 1'b1;
    cycle(); cycle();
    check("R1 after reset outputs", {sDrive, sFast, sSlow}, 0);

    // mixed split: decay 23, fast 15, blank 8
    mixedSel = 1'b1; offCode = 5'd2; fastCode = 4'd1; blankCode = 2'd1;
    runPeriod(9, 15, 8);

    // fast longer than decay: decay 7, fast 31, blank 4 (R8)
    offCode = 5'd0; fastCode = 4'd3; blankCode = 2'd0;
    runPeriod(5, 7, 0);

    // slow mode ignores fast code: decay 31, blank 16 (R9)
    mixedSel = 1'b0; offCode = 5'd3; fastCode = 4'd15; blankCode = 2'd3;
    runPeriod(17, 0, 31);

    // largest codes: decay 255, fast 127, blank 12
    mixedSel = 1'b1; offCode = 5'd31; fastCode = 4'd15; blankCode = 2'd2;
    runPeriod(13, 127, 128);

    // R10: phase toggle in the on phase restarts blanking
    begin
      int n;
      mixedSel = 1'b0; offCode = 5'd0; blankCode = 2'd1;
      runEn = 1'b1; senseTrip = 1'b0;
      for (int i = 0; i < 12; i++) cycle();
      check("R10 in on phase before toggle", sDrive, 1);
      phaseIn = ~phaseIn; senseTrip = 1'b1;
      cycle();
      n = 0;
      while (sDrive && n < 100) begin n++; cycle(); end
      check("R10 drive cycles after toggle", n, blkLen() + 2);
      runEn = 1'b0; senseTrip = 1'b0;
      cycle(); cycle();
    end

    // R2: disable in the middle of decay
    begin
      int n;
      offCode = 5'd3; runEn = 1'b1; senseTrip = 1'b1;
      n = 0;
      cycle();
      while (!sSlow && n < 100) begin n++; cycle(); end
      check("R2 reached decay", sSlow, 1);
      runEn = 1'b0;
      cycle();
      check("R2 decay still shown in disabling cycle", sSlow, 1);
      cycle();
      check("R2 outputs low after disable", {sDrive, sFast, sSlow}, 0);
      senseTrip = 1'b0;
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule